// File: doc/BRIEF.md
# Burst Address Sequencer (linear / interleaved)

This block produces the address stream for four-beat bursts on a synchronous SRAM port. Two start strobes can begin a burst. One comes from a processor and one from a cache controller. On the clock edge that accepts a start, the block captures the external address and the chip-select level. On each later cycle in which the advance input is high, a two-bit beat counter steps. The two low address bits are formed from the captured low bits and the beat count. A static mode pin selects how they combine: in linear order they are added modulo 4, and in interleaved order they are XORed. The upper address bits pass through from the captured address unchanged.

Control is a two-state machine. `ST_IDLE` means no selected burst is open, and `ST_RUN` means a selected burst is open. The machine has three transitions. *open* (`ST_IDLE` to `ST_RUN`) fires when a start is accepted with the select high. *close* (`ST_RUN` to `ST_IDLE`) fires when a start is accepted with the select low. *stay* covers every other cycle. The processor strobe is accepted only while the select is high. The controller strobe is always accepted. Advance steps the counter only in `ST_RUN` and only on a cycle without an accepted start. All outputs come from registers through combinational logic, so they change one clock after the edge that caused the change.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low and after its release, `beat_o` is 0, `active_o` is 0 and `burst_addr_o` is 0 until a start is accepted.
- R2: `ctrl_start_i` high at an edge is accepted whatever `sel_i` is. After that edge `beat_o` is 0, `burst_addr_o` equals the captured `addr_i`, and `active_o` equals the captured `sel_i`.
- R3: `proc_start_i` high at an edge is accepted only when `sel_i` is 1, with the same effect as R2. With `sel_i` at 0 and `ctrl_start_i` at 0, it changes no output.
- R4: When both start strobes are high at the same edge, exactly one load of `addr_i` takes place and `beat_o` becomes 0.
- R5: `adv_i` high, with `active_o` at 1 and no accepted start, increments `beat_o` by 1 modulo 4 after the edge.
- R6: With `mode_i` at 0 (linear), `burst_addr_o[1:0]` equals (captured low bits + `beat_o`) mod 4.
- R7: With `mode_i` at 1 (interleaved), `burst_addr_o[1:0]` equals captured low bits XOR `beat_o`.
- R8: After four advances, `beat_o` is back at 0 and the same four-address sequence repeats.
- R9: On a cycle with no accepted start and no advance, `beat_o`, `active_o` and `burst_addr_o` keep their values. Bits above bit 1 of `burst_addr_o` change only on an accepted start.
- R10: When an accepted start and `adv_i` fall on the same edge, the start wins and `beat_o` becomes 0.
- R11: `adv_i` while `active_o` is 0 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| sel_i | input | 1 | Combined chip select, 1 = selected |
| proc_start_i | input | 1 | Processor start strobe, active high |
| ctrl_start_i | input | 1 | Cache-controller start strobe, active high |
| adv_i | input | 1 | Advance to next beat, active high |
| addr_i | input | ADDR_W | External start address |
| burst_addr_o | output | ADDR_W | Current burst address |
| beat_o | output | CNT_W | Current beat index |
| active_o | output | 1 | A selected burst is open (`ST_RUN`) |

## Verification
The two functions that can fall in the same cycle are a burst start and a beat advance. They meet when either strobe is raised on the same edge as `adv_i`. They also meet when the processor strobe arrives while the chip is deselected and the controller strobe is raised alongside it. The bench provokes both cases in directed steps and again in a long pseudo-random stream. In every cycle it compares the outputs with a model computed from R2 to R11. The start must win with a beat of 0, and a processor-only strobe while deselected must leave the outputs untouched.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } bseq_state_t;
endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
    import bseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic proc_start_i,
    input  logic ctrl_start_i,
    input  logic adv_i,
    output logic load_o,
    output logic step_o,
    output logic active_o
);
    bseq_state_t state_q, state_d;
    logic accept;

    assign accept = ctrl_start_i | (proc_start_i & sel_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && sel_i)  state_d = ST_RUN;   // open
            ST_RUN:  if (accept && !sel_i) state_d = ST_IDLE;  // close
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        load_o   = accept;
        step_o   = 1'b0;
        active_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                active_o = 1'b0;
                step_o   = 1'b0;
            end
            ST_RUN: begin
                active_o = 1'b1;
                step_o   = adv_i & ~accept;
            end
            default: begin
                active_o = 1'b0;
                step_o   = 1'b0;
            end
        endcase
    end

    // R3: a processor-only strobe while deselected leaves the state alone
    assert_proc_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_start_i && !sel_i && !ctrl_start_i) |=> (state_q == $past(state_q)));

    // R11: advance in idle keeps the machine idle
    assert_idle_adv_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && adv_i && !ctrl_start_i && !proc_start_i) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/bseq_beat_cnt.sv
module bseq_beat_cnt #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clear_i) cnt_q <= '0;
        else if (step_i)  cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R2 / R10: an accepted start restarts the beat at zero
    assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_o == '0));

    // R5 / R8: a step moves one beat forward, wrapping at the top
    assert_step_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clear_i) |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));

    // R9: no start and no step keeps the beat
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !clear_i) |=> $stable(cnt_o));
endmodule

// File: rtl/bseq_start_reg.sv
module bseq_start_reg #(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] start_o
);
    logic [ADDR_W-1:0] start_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      start_q <= '0;
        else if (load_i) start_q <= addr_i;
    end

    assign start_o = start_q;

    // R2: the captured address is the one presented at the accepting edge
    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (start_o == $past(addr_i)));
endmodule

// File: rtl/bseq_order_mix.sv
module bseq_order_mix #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             mode_i,
    input  logic [CNT_W-1:0] base_i,
    input  logic [CNT_W-1:0] beat_i,
    output logic [CNT_W-1:0] low_o
);
    logic [CNT_W-1:0] lin_low;
    logic [CNT_W-1:0] ilv_low;

    assign lin_low = base_i + beat_i;

    for (genvar b = 0; b < CNT_W; b++) begin : g_ilv
        assign ilv_low[b] = base_i[b] ^ beat_i[b];
    end

    always_comb begin
        if (mode_i) low_o = ilv_low;
        else        low_o = lin_low;
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              sel_i,
    input  logic              proc_start_i,
    input  logic              ctrl_start_i,
    input  logic              adv_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] burst_addr_o,
    output logic [CNT_W-1:0]  beat_o,
    output logic              active_o
);
    localparam int unsigned HI_W = ADDR_W - CNT_W;

    logic              load;
    logic              step;
    logic [ADDR_W-1:0] start;
    logic [CNT_W-1:0]  beat;
    logic [CNT_W-1:0]  low;

    bseq_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_i        (sel_i),
        .proc_start_i (proc_start_i),
        .ctrl_start_i (ctrl_start_i),
        .adv_i        (adv_i),
        .load_o       (load),
        .step_o       (step),
        .active_o     (active_o)
    );

    bseq_start_reg #(.ADDR_W(ADDR_W)) u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .addr_i  (addr_i),
        .start_o (start)
    );

    bseq_beat_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (load),
        .step_i  (step),
        .cnt_o   (beat)
    );

    bseq_order_mix #(.CNT_W(CNT_W)) u_mix (
        .mode_i (mode_i),
        .base_i (start[CNT_W-1:0]),
        .beat_i (beat),
        .low_o  (low)
    );

    assign burst_addr_o = {start[ADDR_W-1:CNT_W], low};
    assign beat_o       = beat;

    // R6 / R7: the first beat of every burst is the captured start address
    assert_first_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_o == '0) |-> (burst_addr_o[CNT_W-1:0] == start[CNT_W-1:0]));

    // R9: upper address bits move only with an accepted start
    assert_upper_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (burst_addr_o[ADDR_W-1:CNT_W] == $past(burst_addr_o[ADDR_W-1:CNT_W])));

    // R11: no beat movement while no selected burst is open
    assert_idle_beat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && !load) |=> $stable(beat_o));

    // R1: reset leaves no burst open
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!active_o && beat_o == '0));

    initial begin
        assert_width_ok_R6: assert (HI_W >= 1);
    end
endmodule

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
    localparam int ADDR_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode = 1'b0, sel = 1'b0, ps = 1'b0, cs = 1'b0, adv = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [ADDR_W-1:0] burst_addr;
    logic [1:0] beat;
    logic active;

    int errors = 0;
    int checks = 0;

    logic [ADDR_W-1:0] m_base = '0;
    logic [1:0] m_beat = '0;
    logic m_active = 1'b0;

    always #5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W), .CNT_W(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .sel_i(sel),
        .proc_start_i(ps), .ctrl_start_i(cs), .adv_i(adv), .addr_i(addr),
        .burst_addr_o(burst_addr), .beat_o(beat), .active_o(active)
    );

    function automatic logic [ADDR_W-1:0] exp_addr();
        logic [1:0] lo;
        lo = mode ? (m_base[1:0] ^ m_beat) : 2'(m_base[1:0] + m_beat);
        return {m_base[ADDR_W-1:2], lo};
    endfunction

    task automatic chk(input string tag);
        logic [ADDR_W-1:0] ea;
        ea = exp_addr();
        checks++;
        if (burst_addr !== ea || beat !== m_beat || active !== m_active) begin
            errors++;
            $display("FAIL %s: addr=%h beat=%0d act=%0b expected addr=%h beat=%0d act=%0b",
                     tag, burst_addr, beat, active, ea, m_beat, m_active);
        end
    endtask

    task automatic cyc(input logic p, input logic c, input logic s, input logic a,
                       input logic [ADDR_W-1:0] ad, input string tag);
        logic acc;
        ps = p; cs = c; sel = s; adv = a; addr = ad;
        @(posedge clk);
        #1;
        acc = c | (p & s);
        if (acc) begin
            m_base = ad; m_beat = 2'd0; m_active = s;
        end else if (a && m_active) begin
            m_beat = m_beat + 2'd1;
        end
        chk(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 in reset");
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 after release");

        // R11: advance before any burst
        cyc(0, 0, 1, 1, 8'h55, "R11 adv in idle");
        // R3: processor strobe while deselected
        cyc(1, 0, 0, 0, 8'h77, "R3 proc ignored deselected");

        // sweep both orders, every start low value, two upper patterns
        for (int m = 0; m < 2; m++) begin
            mode = m[0];
            for (int st = 0; st < 4; st++) begin
                for (int u = 0; u < 2; u++) begin
                    logic [ADDR_W-1:0] a0;
                    a0 = {(u == 0) ? 6'h00 : 6'h2A, st[1:0]};
                    cyc(0, 1, 1, 0, a0, "R2 ctrl start");
                    for (int k = 0; k < 6; k++)
                        cyc(0, 0, 1, 1, 8'hFF, m ? "R7 R5 R8 interleaved step" : "R6 R5 R8 linear step");
                    cyc(0, 0, 1, 0, 8'h00, "R9 hold");
                    cyc(1, 0, 1, 0, a0 ^ 8'h81, "R3 proc start selected");
                    cyc(0, 0, 1, 1, 8'h00, m ? "R7 step" : "R6 step");
                    cyc(1, 1, 1, 0, a0 ^ 8'h42, "R4 both strobes");
                    cyc(0, 0, 1, 1, 8'h00, "R5 step after dual");
                    cyc(0, 1, 1, 1, a0 ^ 8'h14, "R10 ctrl start with adv");
                    cyc(0, 0, 1, 1, 8'h00, "R5 step");
                    cyc(1, 0, 1, 1, a0 ^ 8'h28, "R10 proc start with adv");
                    cyc(1, 0, 0, 1, 8'hC3, "R3 proc deselected with adv");
                    cyc(1, 1, 0, 1, a0 ^ 8'h99, "R2 ctrl start deselected");
                    cyc(0, 0, 1, 1, 8'h00, "R11 adv after deselect");
                    cyc(0, 0, 0, 0, 8'h00, "R9 hold idle");
                end
            end
        end

        // pseudo-random stream with frequent collisions
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (i % 150 == 0) mode = ~mode;
            cyc(lfsr[0] & lfsr[5], lfsr[1] & lfsr[6] & lfsr[9], lfsr[2] | lfsr[7], lfsr[3],
                lfsr[15:8], "R4 R5 R6 R7 R10 random mix");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule